// File: doc/BRIEF.md
# Output Range Clamp Unit

This unit sits at the end of a pixel pipeline and keeps each of three 12-bit colour components within a legal range before the pixel leaves the chip. A 3-bit format code and an enable bit choose the rule. With the enable bit clear, or in full-range operation, pixels pass through unchanged. With the enable bit set, the unit applies one of two kinds of range. One kind is a fixed limited range that matches a video bit depth of 8, 10 or 12 bits. The other kind is a programmable mode, in which each component has its own lower and upper bound.

The fixed bounds are scaled so that the most significant bits line up in 12 bits. For all three depths this gives the same pair of values, 0x100 and 0xEB0. The codes differ only in the depth they name.

The result is registered, so it appears one cycle after the input, together with a valid flag. Software is expected to clear the control to disabled with format 0 before it selects a new mode. The programmable bounds are set to 0x010 and 0xFEF by default.

Top module: `pix_range_limiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_pix is all zeros.
- R2: out_valid equals the in_valid value sampled at the previous rising clock edge. When in_valid is 1, out_pix carries the result for the inputs sampled at that same edge.
- R3: When clamp_en is 0, out_pix equals in_pix for every format code.
- R4: When clamp_en is 1 and clamp_fmt is 0 (6-bit, no clamping), out_pix equals in_pix.
- R5: When clamp_en is 1 and clamp_fmt is 1 (8-bit limited), each component is limited to the range 0x100 to 0xEB0.
- R6: When clamp_en is 1 and clamp_fmt is 2 (10-bit limited), each component is limited to the range 0x100 to 0xEB0, which is 64..940 shifted left by 2.
- R7: When clamp_en is 1 and clamp_fmt is 3 (12-bit limited), each component is limited to the range 256 to 3760.
- R8: When clamp_en is 1 and clamp_fmt is 7 (programmable), component k is limited to the range prog_lo[k] to prog_hi[k]. Component k occupies bits [12k+11:12k], with component 0 in the lowest bits.
- R9: When clamp_en is 1 and clamp_fmt is 4, 5 or 6, out_pix equals in_pix.
- R10: In every limiting mode, a value below the lower bound becomes the lower bound, and a value above the upper bound becomes the upper bound. Any other value is kept. The three components are handled independently in the same cycle.
- R11: When in_valid is 0, out_pix keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 36 | Three 12-bit components, component 0 in the lowest bits |
| clamp_en | input | 1 | Enables range limiting |
| clamp_fmt | input | 3 | Format code: 0 six-bit, 1/2/3 limited 8/10/12-bit, 7 programmable |
| prog_lo | input | 36 | Per-component lower bounds for the programmable mode |
| prog_hi | input | 36 | Per-component upper bounds for the programmable mode |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 36 | Limited pixel, same layout as in_pix |

## Verification
The lane assertions assume that each programmable lower bound is no greater than its upper bound; an inverted pair has no defined result. The bench applies only ordered pairs, including a pair where the two bounds are equal, so that assumption always holds. The control inputs are changed only at the falling clock edge and are held steady across the capturing edge. This matches the rule that the control is changed between pixels and not during one. The sweep covers all eight format codes with the enable bit both set and clear, steps the component values across the whole 12-bit range, and staggers the three components so that one pixel can hold values below, inside and above the bounds at the same time.

// File: rtl/plim_pkg.sv
package plim_pkg;

  // clamp format codes
  localparam logic [2:0] FMT_SIX   = 3'd0;
  localparam logic [2:0] FMT_LIM8  = 3'd1;
  localparam logic [2:0] FMT_LIM10 = 3'd2;
  localparam logic [2:0] FMT_LIM12 = 3'd3;
  localparam logic [2:0] FMT_PROG  = 3'd7;

  // video limited-range bounds at 8 bits
  localparam int LIM8_LO = 16;
  localparam int LIM8_HI = 235;

  // lower bound for a given depth, MSB-aligned into cw bits
  function automatic int lim_lo(input int depth, input int cw);
    return (LIM8_LO << (depth - 8)) << (cw - depth);
  endfunction

  // upper bound: 235 at 8 bits scales to 940 at 10 bits, 3760 at 12 bits
  function automatic int lim_hi(input int depth, input int cw);
    return (LIM8_HI << (depth - 8)) << (cw - depth);
  endfunction

  // limit a value to [lo, hi]; lower check first
  function automatic logic [31:0] limit(input logic [31:0] x,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

endpackage

// File: rtl/plim_mode_dec.sv
module plim_mode_dec #(
  parameter int CW = 12
) (
  input  logic          clamp_en,
  input  logic [2:0]    clamp_fmt,
  output logic          bypass,
  output logic          use_prog,
  output logic [CW-1:0] fix_lo,
  output logic [CW-1:0] fix_hi
);
  import plim_pkg::*;

  localparam logic [CW-1:0] LO8  = CW'(lim_lo(8, CW));
  localparam logic [CW-1:0] HI8  = CW'(lim_hi(8, CW));
  localparam logic [CW-1:0] LO10 = CW'(lim_lo(10, CW));
  localparam logic [CW-1:0] HI10 = CW'(lim_hi(10, CW));
  localparam logic [CW-1:0] LO12 = CW'(lim_lo(12, CW));
  localparam logic [CW-1:0] HI12 = CW'(lim_hi(12, CW));

  always_comb begin
    bypass   = 1'b1;
    use_prog = 1'b0;
    fix_lo   = '0;
    fix_hi   = '1;
    if (clamp_en) begin
      case (clamp_fmt)
        FMT_LIM8:  begin bypass = 1'b0; fix_lo = LO8;  fix_hi = HI8;  end
        FMT_LIM10: begin bypass = 1'b0; fix_lo = LO10; fix_hi = HI10; end
        FMT_LIM12: begin bypass = 1'b0; fix_lo = LO12; fix_hi = HI12; end
        FMT_PROG:  begin bypass = 1'b0; use_prog = 1'b1; end
        default:   bypass = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/plim_lane.sv
module plim_lane #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] x,
  input  logic          bypass,
  input  logic          use_prog,
  input  logic [CW-1:0] fix_lo,
  input  logic [CW-1:0] fix_hi,
  input  logic [CW-1:0] prog_lo,
  input  logic [CW-1:0] prog_hi,
  output logic [CW-1:0] y
);
  import plim_pkg::*;

  logic [CW-1:0] lo, hi, lim;
  logic          below, above;

  assign lo    = use_prog ? prog_lo : fix_lo;
  assign hi    = use_prog ? prog_hi : fix_hi;
  assign below = x < lo;
  assign above = x > hi;
  assign lim   = CW'(limit(32'(x), 32'(lo), 32'(hi)));
  assign y     = bypass ? x : lim;

  always_comb begin
    if (!bypass && lo <= hi) begin
      // R10
      in_bounds_chk: assert (y >= lo && y <= hi);
      // R10
      keep_inside_chk: assert (below || above || y == x);
    end
  end

endmodule

// File: rtl/pix_range_limiter.sv
module pix_range_limiter #(
  parameter int CW    = 12,
  parameter int NCOMP = 3,
  localparam int PW   = CW * NCOMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] in_pix,
  input  logic          clamp_en,
  input  logic [2:0]    clamp_fmt,
  input  logic [PW-1:0] prog_lo,
  input  logic [PW-1:0] prog_hi,
  output logic          out_valid,
  output logic [PW-1:0] out_pix
);

  logic          bypass, use_prog;
  logic [CW-1:0] fix_lo, fix_hi;
  logic [PW-1:0] lim_pix;

  plim_mode_dec #(.CW(CW)) u_dec (
    .clamp_en (clamp_en),
    .clamp_fmt(clamp_fmt),
    .bypass   (bypass),
    .use_prog (use_prog),
    .fix_lo   (fix_lo),
    .fix_hi   (fix_hi)
  );

  for (genvar k = 0; k < NCOMP; k++) begin : g_lane
    plim_lane #(.CW(CW)) u_lane (
      .x       (in_pix[k*CW +: CW]),
      .bypass  (bypass),
      .use_prog(use_prog),
      .fix_lo  (fix_lo),
      .fix_hi  (fix_hi),
      .prog_lo (prog_lo[k*CW +: CW]),
      .prog_hi (prog_hi[k*CW +: CW]),
      .y       (lim_pix[k*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= lim_pix;
    end
  end

  // one clean edge since reset, so $past refers to post-reset samples
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_valid == $past(in_valid));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(in_valid) |-> $stable(out_pix));

  // R3
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(in_valid) && $past(bypass) |-> out_pix == $past(in_pix));

  // R1
  reset_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid && out_pix == '0);

endmodule

// File: tb/pix_range_limiter_test.sv
module pix_range_limiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_pix = '0;
  logic        clamp_en = 1'b0;
  logic [2:0]  clamp_fmt = 3'd0;
  logic [35:0] prog_lo, prog_hi;
  logic        out_valid;
  logic [35:0] out_pix;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pix_range_limiter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .clamp_en(clamp_en), .clamp_fmt(clamp_fmt),
    .prog_lo(prog_lo), .prog_hi(prog_hi),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // programmable bounds: comp0 default, comp1 mid window, comp2 one-wide
  localparam int PLO [3] = '{16, 512, 1024};
  localparam int PHI [3] = '{4079, 2048, 1024};
  initial begin
    prog_lo = {12'(PLO[2]), 12'(PLO[1]), 12'(PLO[0])};
    prog_hi = {12'(PHI[2]), 12'(PHI[1]), 12'(PHI[0])};
  end

  function automatic int model(int x, bit en, int fmt, int k);
    int lo, hi;
    if (!en) return x;
    case (fmt)
      1, 2, 3: begin lo = 256; hi = 3760; end
      7:       begin lo = PLO[k]; hi = PHI[k]; end
      default: return x;
    endcase
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic string tag(bit en, int fmt);
    if (!en) return "R3";
    case (fmt)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int c [3];
    repeat (3) @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 pix", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after", int'(out_valid), 0);
    check("R1 pix after", int'(out_pix), 0);

    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 8; f++) begin
        for (int x = 0; x < 4096; x += 7) begin
          c[0] = x;
          c[1] = (x + 1365) % 4096;
          c[2] = (x + 2730) % 4096;
          clamp_en  = e[0];
          clamp_fmt = 3'(f);
          in_pix    = {12'(c[2]), 12'(c[1]), 12'(c[0])};
          in_valid  = 1'b1;
          @(negedge clk);
          check("R2 valid", int'(out_valid), 1);
          for (int k = 0; k < 3; k++)
            check($sformatf("%s R10 comp%0d", tag(e[0], f), k),
                  int'(out_pix[k*12 +: 12]), model(c[k], e[0], f, k));
        end
      end
    end

    // exact boundaries in the fixed mode
    begin
      int edges [6] = '{255, 256, 257, 3759, 3760, 3761};
      clamp_en = 1'b1; clamp_fmt = 3'd1;
      for (int i = 0; i < 6; i++) begin
        in_pix = {3{12'(edges[i])}};
        @(negedge clk);
        for (int k = 0; k < 3; k++)
          check("R5 edge", int'(out_pix[k*12 +: 12]), model(edges[i], 1, 1, k));
      end
    end

    // hold while invalid: inputs change, output must not
    begin
      logic [35:0] held;
      held = out_pix;
      in_valid = 1'b0;
      in_pix = 36'h123456789;
      clamp_fmt = 3'd0;
      @(negedge clk);
      check("R2 valid low", int'(out_valid), 0);
      check("R11 hold lo", int'(out_pix[17:0]), int'(held[17:0]));
      check("R11 hold hi", int'(out_pix[35:18]), int'(held[35:18]));
      @(negedge clk);
      check("R11 hold again", int'(out_pix[17:0]), int'(held[17:0]));
    end

    finish_up();
  end

endmodule